// File: doc/BRIEF.md
# Center-of-Gravity Defuzzifier

This block turns weighted consequent records into crisp output values, one output variable at a time. Each record holds two precomputed terms for one consequent membership function: its area scaled by the abscissa of its centroid, and its area alone. Both terms are referenced to the top truth level. A 4-bit weight arrives with each record and scales both terms on the fly. Two parallel accumulators sum the weighted terms into a numerator and a denominator. At the end of each variable's record list, a shift-subtract divider forms the 10-bit quotient.

A batch is launched with a start pulse that also carries the number of variables, encoded as the count minus one. For each result, the block raises a one-cycle strobe and shows the result on the output bus together with its variable index. Both values are held until the next strobe. Two status lines frame the batch. The end-process line stays high for the whole batch. The new-process line drops early, once the strobe for the second-to-last variable ends. This lets the next acquisition overlap the computation of the final value.

Top module: `cog_defuzz`

## Requirements
- R1: After reset, `stb_o`, `new_proc_o`, `end_proc_o` and `rec_ready_o` are 0, and `out_o` and `var_idx_o` are 0.
- R2: For each variable, `out_o` equals floor(sum(theta*ax) / sum(theta*a)) over that variable's records, where `rec_th_i` is an unsigned 4-bit weight and both record terms are unsigned 16-bit values.
- R3: The sums stay exact, with no wrap, for up to 128 records per variable, all holding 16-bit terms at full weight 15.
- R4: When the weighted denominator sum is zero, the result is 0.
- R5: When the true quotient is 1024 or more, the result saturates at 1023.
- R6: `stb_o` is high for exactly one cycle per result. `out_o` and `var_idx_o` change only in a cycle where `stb_o` is high, and hold until the next strobe.
- R7: With `nvar_i` = N-1 sampled at start, N results are produced, with `var_idx_o` equal to 0, 1, ..., N-1 in that order.
- R8: `new_proc_o` rises with the start and falls in the cycle after the strobe of variable N-2. For N = 1 it falls after the only strobe.
- R9: `end_proc_o` rises with the start, stays high through the last strobe, and falls in the cycle after it.
- R10: A record is accepted only on a cycle where `rec_valid_i` and `rec_ready_o` are both high. `rec_last_i` marks the final record of the current variable. A `start_i` pulse while `end_proc_o` is high is ignored and does not disturb the running batch.

Sampling at start: `nvar_i` is read only on the cycle that `start_i` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a batch; ignored while `end_proc_o` is high |
| nvar_i | input | 4 | Number of output variables minus one, sampled at start |
| rec_valid_i | input | 1 | A record is present on the record inputs |
| rec_last_i | input | 1 | Final record of the current variable |
| rec_ax_i | input | 16 | Area times centroid abscissa |
| rec_a_i | input | 16 | Area |
| rec_th_i | input | 4 | Weight of the record |
| rec_ready_o | output | 1 | Block is collecting records |
| out_o | output | 10 | Crisp result |
| var_idx_o | output | 4 | Index of the variable shown on `out_o` |
| stb_o | output | 1 | One-cycle result strobe |
| new_proc_o | output | 1 | A new acquisition may not yet begin while high |
| end_proc_o | output | 1 | Batch in progress |

## Verification
The properties assume well-formed input:
- `start_i` is a single-cycle pulse.
- Every variable ends with a record that has `rec_last_i` set.
- Record inputs hold their values until `rec_ready_o` accepts them.

The stimulus drives inputs on the falling edge. It keeps each record asserted until a rising edge sees `rec_ready_o` high. It issues a start only while idle, except in the one scenario that deliberately tests R10. Because of these rules, the strobe, hold and status-line checks relate only to sequences the block is specified to handle.

// File: rtl/cog_pkg.sv
package cog_pkg;
  localparam int REC_W    = 16;
  localparam int TH_W     = 4;
  localparam int Q_W      = 10;
  localparam int IDX_W    = 4;
  localparam int MAX_RECS = 128;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_LAUNCH,
    ST_WAIT,
    ST_POST
  } seq_state_e;
endpackage

// File: rtl/cog_accum.sv
module cog_accum #(
  parameter int REC_W = 16,
  parameter int TH_W  = 4,
  parameter int ACC_W = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [REC_W-1:0] ax_i,
  input  logic [REC_W-1:0] a_i,
  input  logic [TH_W-1:0]  th_i,
  output logic [ACC_W-1:0] num_o,
  output logic [ACC_W-1:0] den_o
);
  logic [REC_W-1:0] term   [2];
  logic [ACC_W-1:0] sum_q  [2];

  assign term[0] = ax_i;
  assign term[1] = a_i;

  for (genvar l = 0; l < 2; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   sum_q[l] <= '0;
      else if (clr_i) sum_q[l] <= '0;
      else if (en_i) sum_q[l] <= sum_q[l] + ACC_W'(term[l]) * ACC_W'(th_i);
    end
  end

  assign num_o = sum_q[0];
  assign den_o = sum_q[1];
endmodule

// File: rtl/cog_div.sv
module cog_div #(
  parameter int ACC_W = 27,
  parameter int Q_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ACC_W-1:0] num_i,
  input  logic [ACC_W-1:0] den_i,
  output logic             done_o,
  output logic [Q_W-1:0]   quo_o
);
  localparam int SH_W  = ACC_W + Q_W;
  localparam int CNT_W = $clog2(Q_W + 1);

  logic [ACC_W-1:0] rem_q;
  logic [SH_W-1:0]  dsh_q;
  logic [Q_W-1:0]   quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q;
  logic             ovf, ge;

  assign ovf = {{Q_W{1'b0}}, num_i} >= {den_i, {Q_W{1'b0}}};
  assign ge  = {{Q_W{1'b0}}, rem_q} >= dsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; dsh_q <= '0; quo_q <= '0;
      cnt_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        if (den_i == '0) begin
          quo_q <= '0;
          done_q <= 1'b1;
        end else if (ovf) begin
          quo_q <= '1;
          done_q <= 1'b1;
        end else begin
          rem_q <= num_i;
          dsh_q <= SH_W'(den_i) << (Q_W - 1);
          quo_q <= '0;
          cnt_q <= CNT_W'(Q_W);
          run_q <= 1'b1;
        end
      end else if (run_q) begin
        if (ge) rem_q <= rem_q - dsh_q[ACC_W-1:0];
        quo_q <= {quo_q[Q_W-2:0], ge};
        dsh_q <= dsh_q >> 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/cog_seq.sv
module cog_seq
  import cog_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] nvar_i,
  input  logic             rec_valid_i,
  input  logic             rec_last_i,
  input  logic             div_done_i,
  output logic             rec_ready_o,
  output logic             acc_clr_o,
  output logic             div_start_o,
  output logic             cap_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             stb_o,
  output logic             new_proc_o,
  output logic             end_proc_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             np_q, ep_q;
  logic             final_var, near_end;

  assign final_var = (idx_q == last_q);
  assign near_end  = ({1'b0, idx_q} + 1'b1) >= {1'b0, last_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q <= '0; last_q <= '0;
      np_q <= 1'b0; ep_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ACC;
          idx_q <= '0;
          last_q <= nvar_i;
          np_q <= 1'b1;
          ep_q <= 1'b1;
        end
        ST_ACC:    if (rec_valid_i && rec_last_i) state_q <= ST_LAUNCH;
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT:   if (div_done_i) state_q <= ST_POST;
        ST_POST: begin
          if (near_end) np_q <= 1'b0;
          if (final_var) begin
            ep_q <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            state_q <= ST_ACC;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rec_ready_o = (state_q == ST_ACC);
  assign acc_clr_o   = ((state_q == ST_IDLE) && start_i) ||
                       ((state_q == ST_POST) && !final_var);
  assign div_start_o = (state_q == ST_LAUNCH);
  assign cap_o       = (state_q == ST_WAIT) && div_done_i;
  assign stb_o       = (state_q == ST_POST);
  assign idx_o       = idx_q;
  assign new_proc_o  = np_q;
  assign end_proc_o  = ep_q;
endmodule

// File: rtl/cog_defuzz.sv
module cog_defuzz #(
  parameter int REC_W    = cog_pkg::REC_W,
  parameter int TH_W     = cog_pkg::TH_W,
  parameter int Q_W      = cog_pkg::Q_W,
  parameter int IDX_W    = cog_pkg::IDX_W,
  parameter int MAX_RECS = cog_pkg::MAX_RECS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] nvar_i,
  input  logic             rec_valid_i,
  input  logic             rec_last_i,
  input  logic [REC_W-1:0] rec_ax_i,
  input  logic [REC_W-1:0] rec_a_i,
  input  logic [TH_W-1:0]  rec_th_i,
  output logic             rec_ready_o,
  output logic [Q_W-1:0]   out_o,
  output logic [IDX_W-1:0] var_idx_o,
  output logic             stb_o,
  output logic             new_proc_o,
  output logic             end_proc_o
);
  localparam int ACC_W = REC_W + TH_W + $clog2(MAX_RECS);

  logic             acc_clr, div_start, div_done, cap;
  logic [ACC_W-1:0] num, den;
  logic [Q_W-1:0]   quo, out_q;
  logic [IDX_W-1:0] idx, idx_out_q;

  cog_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni, .start_i, .nvar_i, .rec_valid_i, .rec_last_i,
    .div_done_i (div_done),
    .rec_ready_o,
    .acc_clr_o  (acc_clr),
    .div_start_o(div_start),
    .cap_o      (cap),
    .idx_o      (idx),
    .stb_o, .new_proc_o, .end_proc_o
  );

  cog_accum #(.REC_W(REC_W), .TH_W(TH_W), .ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni,
    .clr_i(acc_clr),
    .en_i (rec_valid_i && rec_ready_o),
    .ax_i (rec_ax_i),
    .a_i  (rec_a_i),
    .th_i (rec_th_i),
    .num_o(num),
    .den_o(den)
  );

  cog_div #(.ACC_W(ACC_W), .Q_W(Q_W)) u_div (
    .clk_i, .rst_ni,
    .start_i(div_start),
    .num_i  (num),
    .den_i  (den),
    .done_o (div_done),
    .quo_o  (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      idx_out_q <= '0;
    end else if (cap) begin
      out_q <= quo;
      idx_out_q <= idx;
    end
  end

  assign out_o     = out_q;
  assign var_idx_o = idx_out_q;
endmodule

// File: rtl/cog_defuzz_chk.sv
module cog_defuzz_chk #(
  parameter int Q_W   = 10,
  parameter int IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rec_ready_o,
  input logic [Q_W-1:0]   out_o,
  input logic [IDX_W-1:0] var_idx_o,
  input logic             stb_o,
  input logic             new_proc_o,
  input logic             end_proc_o
);
  a_r6_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
  a_r6_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_o) |-> stb_o);
  a_r6_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(var_idx_o) |-> stb_o);
  a_r8_np_inside_ep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_proc_o |-> !new_proc_o);
  a_r9_stb_inside_ep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |-> end_proc_o);
  a_r9_ep_fall_after_stb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(end_proc_o) |-> $past(stb_o));
  a_r10_ready_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o |-> (end_proc_o && !stb_o));
endmodule

bind cog_defuzz cog_defuzz_chk #(.Q_W(Q_W), .IDX_W(IDX_W)) u_chk (
  .clk_i, .rst_ni, .rec_ready_o, .out_o, .var_idx_o, .stb_o,
  .new_proc_o, .end_proc_o
);

// File: tb/cog_defuzz_bench.sv
module cog_defuzz_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  nvar_i = '0;
  logic        rec_valid_i = 1'b0, rec_last_i = 1'b0;
  logic [15:0] rec_ax_i = '0, rec_a_i = '0;
  logic [3:0]  rec_th_i = '0;
  logic        rec_ready_o, stb_o, new_proc_o, end_proc_o;
  logic [9:0]  out_o;
  logic [3:0]  var_idx_o;

  int checks = 0, fails = 0;
  int v_len [16];
  int r_ax [512], r_a [512], r_th [512];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cog_defuzz u_cog_defuzz (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_rec(input int ax, input int a, input int th, input bit last);
    @(negedge clk_i);
    rec_valid_i = 1'b1; rec_last_i = last;
    rec_ax_i = 16'(ax); rec_a_i = 16'(a); rec_th_i = 4'(th);
    while (!rec_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    rec_valid_i = 1'b0; rec_last_i = 1'b0;
  endtask

  // inject: variable index before whose records a stray start is pulsed (-1: none)
  task automatic run_batch(input int nv, input int inject);
    int base = 0;
    @(negedge clk_i);
    nvar_i = 4'(nv - 1); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(end_proc_o == 1'b1, "R9 ep rise", end_proc_o, 1);
    chk(new_proc_o == 1'b1, "R8 np rise", new_proc_o, 1);
    for (int v = 0; v < nv; v++) begin
      longint num = 0, den = 0, exp_q;
      int wait_n = 0;
      logic [9:0] held;
      if (v == inject) begin
        @(negedge clk_i); start_i = 1'b1; nvar_i = 4'd0;
        @(negedge clk_i); start_i = 1'b0;
      end
      for (int r = 0; r < v_len[v]; r++) begin
        num += longint'(r_ax[base + r]) * r_th[base + r];
        den += longint'(r_a[base + r]) * r_th[base + r];
        send_rec(r_ax[base + r], r_a[base + r], r_th[base + r], r == v_len[v] - 1);
      end
      base += v_len[v];
      exp_q = (den == 0) ? 0 : ((num >= den * 1024) ? 1023 : num / den);
      while (!stb_o && wait_n < 100) begin @(negedge clk_i); wait_n++; end
      chk(stb_o == 1'b1, "R6 strobe seen", stb_o, 1);
      chk(out_o == 10'(exp_q), "R2 value", out_o, exp_q);
      chk(var_idx_o == 4'(v), "R7 index", var_idx_o, v);
      chk(new_proc_o == ((v == 0) || (v < nv - 1)), "R8 np during strobe",
          new_proc_o, (v == 0) || (v < nv - 1));
      held = out_o;
      @(negedge clk_i);
      chk(stb_o == 1'b0, "R6 strobe one cycle", stb_o, 0);
      chk(out_o == held, "R6 out hold", out_o, held);
      chk(new_proc_o == (v < nv - 2), "R8 np after strobe", new_proc_o, v < nv - 2);
      chk(end_proc_o == (v < nv - 1), "R9 ep after strobe", end_proc_o, v < nv - 1);
    end
  endtask

  task automatic t_reset;
    chk(stb_o == 0 && new_proc_o == 0 && end_proc_o == 0 && rec_ready_o == 0,
        "R1 control lines", {stb_o, new_proc_o, end_proc_o, rec_ready_o}, 0);
    chk(out_o == 0 && var_idx_o == 0, "R1 data", out_o, 0);
  endtask

  task automatic t_basic;
    v_len[0] = 2;
    r_ax[0] = 100 * 300; r_a[0] = 100; r_th[0] = 15;
    r_ax[1] = 50 * 600;  r_a[1] = 50;  r_th[1] = 7;
    run_batch(1, -1); // R2 weighted centroid, single variable
  endtask

  task automatic t_zero_den;
    v_len[0] = 3;
    for (int i = 0; i < 3; i++) begin r_ax[i] = 9000 + i; r_a[i] = 40; r_th[i] = 0; end
    run_batch(1, -1); // R4 all weights zero
  endtask

  task automatic t_saturate;
    v_len[0] = 1;
    r_ax[0] = 65535; r_a[0] = 1; r_th[0] = 1;
    run_batch(1, -1); // R5 quotient above 1023
  endtask

  task automatic t_wide_sum;
    v_len[0] = 128;
    for (int i = 0; i < 128; i++) begin r_ax[i] = 65535; r_a[i] = 40000; r_th[i] = 15; end
    run_batch(1, -1); // R3 full-scale 128 records
  endtask

  task automatic t_multi;
    int k = 0;
    for (int v = 0; v < 4; v++) begin
      v_len[v] = v + 1;
      for (int r = 0; r <= v; r++) begin
        r_a[k] = 20 + 13 * r + v; r_ax[k] = r_a[k] * (100 * v + 37 * r + 5);
        r_th[k] = 3 + 4 * r; k++;
      end
    end
    run_batch(4, -1); // R7 R8 R9 four variables
  endtask

  task automatic t_stray_start;
    v_len[0] = 1; v_len[1] = 2;
    r_ax[0] = 10 * 700; r_a[0] = 10; r_th[0] = 9;
    r_ax[1] = 30 * 200; r_a[1] = 30; r_th[1] = 2;
    r_ax[2] = 5 * 900;  r_a[2] = 5;  r_th[2] = 11;
    run_batch(2, 1); // R10 start ignored mid batch
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_zero_den();
    t_saturate();
    t_wide_sum();
    t_multi();
    t_stray_start();
    repeat (3) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule